// File: doc/BRIEF.md
# Flash Completion Status Poller

This controller runs on the host side of a flash device. It decides whether a program or erase operation has finished by reading the device's status byte over and over. Bit 6 of that byte flips on every read while the operation runs. Bit 5 rises when the device has exceeded its internal limit. The poller compares bit 6 across two back-to-back reads. A steady bit means the operation is complete. A flipping bit with bit 5 low means polling goes on with another pair of reads.

Bit 5 being high does not by itself mean failure. Toggling may have stopped in the same read that bit 5 rose. So the poller takes one more pair of reads before it decides. If bit 6 is steady in that pair, the result is success. If bit 6 still flips, the result is failure, and the poller asks for a reset command so that the device goes back to array reads.

A host-set limit on the number of flipping pairs guards against a device that never finishes. Reaching the limit gives a distinct timeout result, which also asks for the reset command. An abort returns the poller to idle at once. A later start always begins again with the first read of a fresh pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: Each status read holds `rd_req` high until a cycle with `rd_ack` high. The byte on `rd_data` is taken in that same cycle. A check always uses two such reads in sequence.
- R2: When bit 6 (`rd_data[6]`) is equal in the two reads of a pair, `done` pulses for one cycle in the cycle after the second acknowledge. No further read is requested.
- R3: When bit 6 differs between the two reads of a pair and bit 5 (`rd_data[5]`) of the second read is low, the poller starts a new pair of reads.
- R4: When bit 6 differs and bit 5 of the second read is high, the poller takes one more verify pair. If bit 6 is equal in the verify pair, `done` pulses.
- R5: If bit 6 still differs in the verify pair, `fail` and `rst_cmd` pulse together for one cycle, and `timeout` stays low.
- R6: When `max_polls` is nonzero and the count of flipping pairs with bit 5 low reaches `max_polls`, `fail`, `timeout` and `rst_cmd` pulse together. A value of zero sets no limit.
- R7: `abort` returns the poller to idle on the next edge with no result pulse. A later `start` begins again from the first read of a new pair.
- R8: `busy` is high from the cycle after an accepted `start` and falls in the cycle where the result pulses. A `start` while busy is ignored. `done`, `fail`, `timeout` and `rst_cmd` last one cycle each.
- R9: After reset, `busy`, `rd_req`, `done`, `fail`, `timeout` and `rst_cmd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| abort | input | 1 | Abandon polling, back to idle |
| max_polls | input | CNT_W | Limit on flipping pairs, 0 means no limit |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | DW | Status byte |
| rst_cmd | output | 1 | One-cycle request to issue the device reset command |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: operation finished successfully |
| fail | output | 1 | One-cycle pulse: operation failed or timed out |
| timeout | output | 1 | One-cycle pulse with `fail` when the limit is reached |

## Verification
The assertions assume the following about the inputs:
- `rd_ack` comes only while `rd_req` is high.
- `max_polls` stays constant while `busy` is high.
- `start` and `abort` are never high in the same cycle.

The bench keeps to these assumptions:
- Its device model raises the acknowledge only on a cycle where it sees a request, after a random delay.
- It writes the limit only between operations.
- It drives abort only in its own directed cases, with start held low.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int DW      = 8,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] max_polls,
  output logic             rd_req,
  input  logic             rd_ack,
  input  logic [DW-1:0]    rd_data,
  output logic             rst_cmd,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             timeout
);

  typedef enum logic [2:0] {S_IDLE, S_A, S_B, S_VA, S_VB} st_t;

  st_t              st;
  logic             first_q;
  logic [CNT_W-1:0] pairs;
  logic [CNT_W:0]   pairs_inc;
  logic             same, err_bit, limit_hit;

  assign pairs_inc = {1'b0, pairs} + 1'b1;
  assign same      = rd_data[TOG_BIT] == first_q;
  assign err_bit   = rd_data[ERR_BIT];
  assign limit_hit = (max_polls != '0) && (pairs_inc >= {1'b0, max_polls});
  assign busy      = st != S_IDLE;
  assign rd_req    = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      first_q <= 1'b0;
      pairs   <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
      rst_cmd <= 1'b0;
    end else begin
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
      rst_cmd <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st    <= S_A;
            pairs <= '0;
          end
          S_A, S_VA: if (rd_ack) begin
            first_q <= rd_data[TOG_BIT];
            st      <= (st == S_A) ? S_B : S_VB;
          end
          S_B: if (rd_ack) begin
            if (same) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else if (err_bit) begin
              st <= S_VA;
            end else if (limit_hit) begin
              fail    <= 1'b1;
              timeout <= 1'b1;
              rst_cmd <= 1'b1;
              st      <= S_IDLE;
            end else begin
              pairs <= pairs_inc[CNT_W-1:0];
              st    <= S_A;
            end
          end
          S_VB: if (rd_ack) begin
            if (same) begin
              done <= 1'b1;
            end else begin
              fail    <= 1'b1;
              rst_cmd <= 1'b1;
            end
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !abort) |=> rd_req);
  a_r2_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r5_rst_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail == rst_cmd);
  a_r6_timeout_fail: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);
  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done && !fail && !rd_req));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !(done || fail));
  a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fail || $past(abort)));
  a_r8_idle_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);

endmodule

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
  localparam int CNT_W = 16;
  localparam int OK = 0, BAD = 1, TMO = 2;

  logic clk = 0, rst_n = 0, start = 0, abort = 0, rd_ack = 0;
  logic [CNT_W-1:0] max_polls = '0;
  logic [7:0] rd_data = '0;
  logic rd_req, rst_cmd, busy, done, fail, timeout;

  int checks = 0, errors = 0;
  int dev_n = 0, dev_f = 1 << 20, idx = 0;
  bit finished = 0;

  toggle_poll_ctrl #(.CNT_W(CNT_W)) dut (.*);

  always #10 clk = ~clk;

  function automatic bit b6(int i, int n);
    if (i < n) return i[0];
    return (n > 0) ? bit'((n - 1) & 1) : 1'b0;
  endfunction

  function automatic int predict(int n, int f, int maxp, output int reads);
    int i = 0, pairs = 0;
    forever begin
      bit a, b, e;
      a = b6(i, n); b = b6(i + 1, n); e = (i + 1 >= f); i += 2;
      if (a == b) begin reads = i; return OK; end
      if (e) begin
        a = b6(i, n); b = b6(i + 1, n); i += 2; reads = i;
        return (a == b) ? OK : BAD;
      end
      pairs++;
      if (maxp != 0 && pairs >= maxp) begin reads = i; return TMO; end
    end
  endfunction

  always @(negedge clk) begin
    rd_ack = 0;
    if (rd_req && $urandom_range(2) != 0) begin
      rd_ack = 1;
      rd_data = {1'($urandom), b6(idx, dev_n), 1'(idx >= dev_f), 5'($urandom)};
      idx++;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run(int n, int f, int maxp, string tag);
    int exp_reads, exp, got, waited = 0;
    exp = predict(n, f, maxp, exp_reads);
    dev_n = n; dev_f = f; idx = 0; max_polls = CNT_W'(maxp);
    pulse_start();
    check(busy, {"R8 busy after start ", tag}, busy, 1);
    forever begin
      @(negedge clk); start = 0;
      if (done || fail || waited > 3000) break;
      if (busy && $urandom_range(9) == 0) start = 1;
      waited++;
    end
    got = done ? OK : (timeout ? TMO : (fail ? BAD : -1));
    case (exp)
      OK:  check(got == exp, {"R2/R4 success ", tag}, got, exp);
      BAD: check(got == exp, {"R5 failure ", tag}, got, exp);
      default: check(got == exp, {"R6 timeout ", tag}, got, exp);
    endcase
    check(rst_cmd == (exp != OK), {"R5 rst_cmd ", tag}, rst_cmd, exp != OK);
    check(idx == exp_reads, {"R1/R3 read count ", tag}, idx, exp_reads);
    check(!busy, {"R8 busy low at result ", tag}, busy, 0);
    @(negedge clk);
    check(!done && !fail && !rst_cmd && !timeout, {"R8 one-cycle pulse ", tag},
          {done, fail, rst_cmd, timeout}, 0);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(!busy && !rd_req && !done && !fail && !timeout && !rst_cmd, "R9 reset state",
          {busy, rd_req, done, fail, timeout, rst_cmd}, 0);
    rst_n = 1;

    run(0, 1 << 20, 0, "steady");
    run(2, 1 << 20, 0, "one flip pair");
    run(3, 1, 0, "R4 stop as bit5 rises");
    run(100, 3, 0, "R5 still flipping");
    run(100, 1 << 20, 3, "R6 limit 3");
    run(100, 1 << 20, 1, "R6 limit 1");
    run(20, 1 << 20, 0, "R6 zero no limit");
    run(15, 1 << 20, 8, "R3 long poll");

    dev_n = 100; dev_f = 1 << 20; idx = 0; max_polls = '0;
    pulse_start();
    repeat (6) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    check(!busy && !rd_req, "R7 idle after abort", busy, 0);
    begin
      bit seen = 0;
      repeat (10) begin @(negedge clk); seen |= done | fail; end
      check(!seen, "R7 no result after abort", seen, 0);
    end
    run(0, 1 << 20, 0, "R7 restart first read");

    for (int t = 0; t < 60; t++) begin
      int n = $urandom_range(30);
      int f = ($urandom_range(3) == 0) ? (1 << 20) : $urandom_range(40);
      run(n, f, $urandom_range(12), "random");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule